// File: doc/BRIEF.md
# ARX Block Cipher Encryption Core

This block encrypts one 64-bit block under a 128-bit key with an add-rotate-XOR cipher that works on two 32-bit words. It computes one round per clock for 27 rounds. There is no key or data whitening before the first round or after the last. The round keys are generated on the fly, in step with the data rounds. The key expansion is the round function itself: it is fed one key word together with the matching word of a three-entry queue, and the up-counting round index takes the place of the round key.

The user pulses `start_i` while the core is idle or finishing. In that cycle the core captures the key and the plaintext, so every block can use a fresh key. `busy_o` is high while the rounds run. `done_o` pulses for one cycle when the ciphertext is ready. `ct_o` then holds that ciphertext until the next accepted start.

The controller is a three-state machine:
- `ST_IDLE` waits for a start.
- `ST_RUN` computes one round per cycle and counts rounds 0 to 26.
- `ST_FIN` signals completion.

Its transitions are:
- ST_IDLE→ST_RUN on `start_i`; ST_IDLE→ST_IDLE otherwise.
- ST_RUN→ST_RUN while the round index is below 26.
- ST_RUN→ST_FIN after round 26.
- ST_FIN→ST_RUN on `start_i`; ST_FIN→ST_IDLE otherwise.

Top module: `arx64_enc`

## Requirements
- R1: While `rst_n` is low, and after it is released, `busy_o`=0, `done_o`=0 and `ct_o`=0. Asserting `rst_n` low in the middle of a run aborts that run.
- R2: A `start_i` sampled high in `ST_IDLE` or `ST_FIN` raises `busy_o` in the next cycle. `busy_o` stays high for exactly 27 cycles, one round each.
- R3: Each data round maps (x, y) with round key k to x' = ((x rotr 8) + y mod 2^32) XOR k and y' = (y rotl 3) XOR x'.
- R4: Key bits [31:0] are the round-0 key k0. Bits [63:32], [95:64] and [127:96] are the queue words l0, l1 and l2. For round i: l_new = (k_i + (l_i rotr 8)) XOR i, and k_{i+1} = (k_i rotl 3) XOR l_new. Here i counts up from 0.
- R5: `done_o` is high for exactly one cycle, the 28th cycle after the start was sampled. `busy_o` is low in that cycle.
- R6: `ct_o` carries x in bits [63:32] and y in bits [31:0]. The plaintext is loaded the same way. For key 0x1b1a1918_13121110_0b0a0908_03020100 and plaintext 0x3b726574_7475432d, the ciphertext is 0x8c6fa548_454e028b.
- R7: After `done_o`, `ct_o` holds its value until the next accepted start, whatever `key_i` and `pt_i` do.
- R8: A `start_i` pulse while `busy_o` is high is ignored. The current run ends on time, with the result for the key and plaintext captured at its start.
- R9: The key and plaintext are captured only when a start is accepted. Changing `key_i` or `pt_i` during a run has no effect on that run's result.
- R10: A `start_i` in the cycle where `done_o` is high is accepted. The next block then runs back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse; captures key and plaintext |
| key_i | input | 128 | Cipher key {l2, l1, l0, k0} |
| pt_i | input | 64 | Plaintext {x, y} |
| busy_o | output | 1 | High while rounds are computed |
| done_o | output | 1 | One-cycle pulse when ciphertext is valid |
| ct_o | output | 64 | Ciphertext {x, y} |

## Verification
The core is driven with several key and plaintext pairs:
- A published-style known-answer vector, which fixes the word order and the rotation directions.
- All-zero inputs, where only the round counter injects entropy, which isolates the counter in the key expansion.
- All-ones and alternating patterns, which exercise carries through the modular adders.

Three disturbances test the capture rules:
- Inputs changed in mid-run check that key and plaintext are captured only at an accepted start.
- A stray start in mid-run checks that it is ignored.
- A start placed in the completion cycle checks that back-to-back blocks are accepted.

A reset in the middle of a run checks that the run is aborted. A behavioural model compares `busy_o`, `done_o` and `ct_o` every cycle, which also tests the cycle timing.

// File: rtl/arx_pkg.sv
package arx_pkg;
    localparam int WORD      = 32;
    localparam int KEY_WORDS = 4;
    localparam int ROUNDS    = 27;
    localparam int ROT_A     = (WORD == 16) ? 7 : 8;
    localparam int ROT_B     = (WORD == 16) ? 2 : 3;
    localparam int RND_W     = $clog2(ROUNDS);
    localparam int QDEPTH    = KEY_WORDS - 1;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } ctrl_state_t;
endpackage

// File: rtl/arx_round.sv
module arx_round #(
    parameter int W  = 32,
    parameter int RA = 8,
    parameter int RB = 3
) (
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    input  logic [W-1:0] k_i,
    output logic [W-1:0] x_o,
    output logic [W-1:0] y_o
);
    logic [W-1:0] x_rot;
    logic [W-1:0] y_rot;
    logic [W-1:0] sum;

    always_comb begin
        x_rot = (x_i >> RA) | (x_i << (W - RA));
        y_rot = (y_i << RB) | (y_i >> (W - RB));
        sum   = x_rot + y_i;
        x_o   = sum ^ k_i;
        y_o   = y_rot ^ x_o;
    end
endmodule

// File: rtl/arx_ctrl.sv
module arx_ctrl
    import arx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    output logic             load_o,
    output logic             adv_o,
    output logic             busy_o,
    output logic             done_o,
    output logic [RND_W-1:0] rnd_o
);
    localparam logic [RND_W-1:0] LAST = RND_W'(ROUNDS - 1);

    ctrl_state_t state_q, state_d;
    logic [RND_W-1:0] rnd_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i) state_d = ST_RUN;
            ST_RUN:  if (rnd_q == LAST) state_d = ST_FIN;
            ST_FIN:  state_d = start_i ? ST_RUN : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        load_o = 1'b0;
        adv_o  = 1'b0;
        busy_o = 1'b0;
        done_o = 1'b0;
        unique case (state_q)
            ST_IDLE: load_o = start_i;
            ST_RUN: begin
                adv_o  = 1'b1;
                busy_o = 1'b1;
            end
            ST_FIN: begin
                done_o = 1'b1;
                load_o = start_i;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  rnd_q <= '0;
        else if (load_o)             rnd_q <= '0;
        else if (adv_o && rnd_q != LAST) rnd_q <= rnd_q + 1'b1;
    end

    assign rnd_o = rnd_q;

    a_r2_round_step: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && rnd_q != LAST && !load_o) |=> (rnd_q == $past(rnd_q) + 1'b1));
    a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    a_r2_load_zero: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |=> (rnd_q == '0 && busy_o));
endmodule

// File: rtl/arx_keysched.sv
module arx_keysched
    import arx_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      load_i,
    input  logic                      adv_i,
    input  logic [KEY_WORDS*WORD-1:0] key_i,
    input  logic [RND_W-1:0]          rnd_i,
    output logic [WORD-1:0]           rk_o
);
    logic [WORD-1:0] k_q;
    logic [WORD-1:0] lq_q [QDEPTH];
    logic [WORD-1:0] l_new;
    logic [WORD-1:0] k_next;
    logic [WORD-1:0] rnd_word;

    assign rnd_word = {{(WORD-RND_W){1'b0}}, rnd_i};

    arx_round #(.W(WORD), .RA(ROT_A), .RB(ROT_B)) u_kround (
        .x_i (lq_q[0]),
        .y_i (k_q),
        .k_i (rnd_word),
        .x_o (l_new),
        .y_o (k_next)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      k_q <= '0;
        else if (load_i) k_q <= key_i[WORD-1:0];
        else if (adv_i)  k_q <= k_next;
    end

    for (genvar g = 0; g < QDEPTH; g++) begin : g_queue
        logic [WORD-1:0] shift_in;
        if (g == QDEPTH - 1) begin : g_tail
            assign shift_in = l_new;
        end else begin : g_body
            assign shift_in = lq_q[g+1];
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      lq_q[g] <= '0;
            else if (load_i) lq_q[g] <= key_i[(g+1)*WORD +: WORD];
            else if (adv_i)  lq_q[g] <= shift_in;
        end
    end

    assign rk_o = k_q;

    a_r9_key_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !adv_i) |=> $stable(k_q));
endmodule

// File: rtl/arx64_enc.sv
module arx64_enc
    import arx_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start_i,
    input  logic [KEY_WORDS*WORD-1:0] key_i,
    input  logic [2*WORD-1:0]         pt_i,
    output logic                      busy_o,
    output logic                      done_o,
    output logic [2*WORD-1:0]         ct_o
);
    logic             load;
    logic             adv;
    logic [RND_W-1:0] rnd;
    logic [WORD-1:0]  rk;
    logic [WORD-1:0]  x_q, y_q, x_d, y_d;

    arx_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .load_o  (load),
        .adv_o   (adv),
        .busy_o  (busy_o),
        .done_o  (done_o),
        .rnd_o   (rnd)
    );

    arx_keysched u_ks (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load),
        .adv_i  (adv),
        .key_i  (key_i),
        .rnd_i  (rnd),
        .rk_o   (rk)
    );

    arx_round #(.W(WORD), .RA(ROT_A), .RB(ROT_B)) u_dround (
        .x_i (x_q),
        .y_i (y_q),
        .k_i (rk),
        .x_o (x_d),
        .y_o (y_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            x_q <= '0;
            y_q <= '0;
        end else if (load) begin
            x_q <= pt_i[2*WORD-1:WORD];
            y_q <= pt_i[WORD-1:0];
        end else if (adv) begin
            x_q <= x_d;
            y_q <= y_d;
        end
    end

    assign ct_o = {x_q, y_q};

    a_r2_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);
    a_r5_done_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);
    a_r7_ct_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> $stable(ct_o));
    a_r5_not_both: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_o && done_o));
endmodule

// File: tb/arx64_enc_test.sv
module arx64_enc_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic [127:0] key_i = '0;
    logic [63:0]  pt_i = '0;
    logic         busy_o, done_o;
    logic [63:0]  ct_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit cmp_en = 0;
    string cur_req = "R1";

    arx64_enc uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .key_i(key_i),
        .pt_i(pt_i), .busy_o(busy_o), .done_o(done_o), .ct_o(ct_o)
    );

    always #2.5 clk = ~clk;

    function automatic logic [31:0] ror8(logic [31:0] v);
        return {v[7:0], v[31:8]};
    endfunction
    function automatic logic [31:0] rol3(logic [31:0] v);
        return {v[28:0], v[31:29]};
    endfunction

    function automatic logic [63:0] ref_enc(logic [127:0] key, logic [63:0] pt);
        logic [31:0] l [0:29];
        logic [31:0] k, x, y;
        l[0] = key[63:32]; l[1] = key[95:64]; l[2] = key[127:96];
        k = key[31:0]; x = pt[63:32]; y = pt[31:0];
        for (int i = 0; i < 27; i++) begin
            x = (ror8(x) + y) ^ k;
            y = rol3(y) ^ x;
            l[i+3] = (k + ror8(l[i])) ^ 32'(i);
            k = rol3(k) ^ l[i+3];
        end
        return {x, y};
    endfunction

    // cycle model: 0 idle, 1 running, 2 finishing
    int          m_st = 0;
    int          m_rnd = 0;
    logic [31:0] m_x = '0, m_y = '0, m_k = '0;
    logic [31:0] m_lq [$];

    always @(posedge clk) begin
        logic [31:0] lnew;
        if (!rst_n) begin
            m_st = 0; m_x = '0; m_y = '0; m_k = '0; m_lq.delete();
        end else if (m_st == 1) begin
            lnew = (m_k + ror8(m_lq[0])) ^ 32'(m_rnd);
            m_x = (ror8(m_x) + m_y) ^ m_k;
            m_y = rol3(m_y) ^ m_x;
            m_k = rol3(m_k) ^ lnew;
            void'(m_lq.pop_front());
            m_lq.push_back(lnew);
            if (m_rnd == 26) m_st = 2;
            else m_rnd++;
        end else if (start_i) begin
            m_x = pt_i[63:32]; m_y = pt_i[31:0]; m_k = key_i[31:0];
            m_lq = '{key_i[63:32], key_i[95:64], key_i[127:96]};
            m_rnd = 0; m_st = 1;
        end else begin
            m_st = 0;
        end
    end

    always @(negedge clk) begin
        if (cmp_en) begin
            checks++;
            if (busy_o !== (m_st == 1) || done_o !== (m_st == 2) || ct_o !== {m_x, m_y}) begin
                errors++;
                $display("FAIL %s cycle model: got busy=%b done=%b ct=%h exp busy=%b done=%b ct=%h",
                         cur_req, busy_o, done_o, ct_o, m_st == 1, m_st == 2, {m_x, m_y});
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog: got %0d cycles exp below 150000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic check(string req, logic [63:0] got, logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h exp %h", req, got, exp);
        end
    endtask

    // mode 0 plain, 1 change inputs mid-run (R9), 2 stray start mid-run (R8)
    task automatic run_block(string req, logic [127:0] key, logic [63:0] pt, int mode);
        int n = 0;
        cur_req = req;
        #1;
        start_i = 1'b1; key_i = key; pt_i = pt;
        forever begin
            @(negedge clk);
            n++;
            if (n == 1) check({req, " busy after start (R2)"}, 64'(busy_o), 64'd1);
            if (done_o || n > 40) break;
            #1;
            start_i = 1'b0;
            if (mode == 1 && n == 5) begin key_i = ~key; pt_i = ~pt; end
            if (mode == 2 && n == 9) begin start_i = 1'b1; key_i = ~key; pt_i = ~pt; end
            if (mode == 2 && n == 10) start_i = 1'b0;
        end
        check({req, " done cycle (R5)"}, 64'(n), 64'd28);
        check({req, " ciphertext (R3 R4)"}, ct_o, ref_enc(key, pt));
    endtask

    initial begin
        logic [63:0] held;
        repeat (3) @(negedge clk);
        check("R1 busy in reset", 64'(busy_o), 64'd0);
        check("R1 ct in reset", ct_o, 64'd0);
        #1 rst_n = 1'b1;
        @(negedge clk);
        cmp_en = 1;
        check("R1 done after reset", 64'(done_o), 64'd0);
        check("R1 ct after reset", ct_o, 64'd0);

        run_block("R6", 128'h1b1a1918_13121110_0b0a0908_03020100, 64'h3b726574_7475432d, 0);
        check("R6 known answer", ct_o, 64'h8c6fa548_454e028b);
        @(negedge clk);
        check("R5 done one cycle", 64'(done_o), 64'd0);

        run_block("R4 zero", '0, '0, 0);
        repeat (2) @(negedge clk);
        run_block("R3 ones", '1, '1, 0);
        repeat (3) @(negedge clk);
        run_block("R3 alt", {4{32'haaaa5555}}, 64'h01234567_89abcdef, 0);
        repeat (2) @(negedge clk);

        run_block("R9", 128'h0f0e0d0c_0b0a0908_07060504_03020100, 64'hdeadbeef_cafef00d, 1);
        held = ct_o;
        cur_req = "R7";
        repeat (20) begin
            @(negedge clk);
            #1 key_i = ~key_i; pt_i = pt_i + 64'd7;
        end
        @(negedge clk);
        check("R7 ct held", ct_o, held);

        run_block("R8", 128'h11112222_33334444_55556666_77778888, 64'h13579bdf_2468ace0, 2);
        run_block("R10", 128'h99990000_aaaa1111_bbbb2222_cccc3333, 64'hfedcba98_76543210, 0);
        run_block("R10 again", 128'h01010101_02020202_03030303_04040404, 64'h0, 0);

        cur_req = "R1";
        #1 start_i = 1'b1; key_i = '1; pt_i = 64'h5;
        @(negedge clk); #1 start_i = 1'b0;
        repeat (6) @(negedge clk);
        #1 rst_n = 1'b0;
        @(negedge clk);
        check("R1 abort busy", 64'(busy_o), 64'd0);
        check("R1 abort ct", ct_o, 64'd0);
        #1 rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 idle after abort", 64'({busy_o, done_o}), 64'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule